// File: doc/BRIEF.md
# Monitor Channel Receive Event Writer

This block sits behind a serial monitor-channel receiver. It takes the bytes of a message as they arrive, decides which of them count, and packs the ones that count into pairs. For each pair, end of message or abort, it writes one entry into a circular event queue held in memory. An entry occupies a fixed slot. Word 0 of the slot is a status word that describes the framing. Word 1 holds up to two message bytes. Word 2, when time stamping is built in, holds a 16-bit free-running cycle count.

There are two receive disciplines, and a mode input picks between them. In dual-reception mode a byte counts only after the same value has arrived twice in a row. There are two ports in this mode, and a port bit in the status word tells them apart. In single-reception mode every byte counts at once, and each byte becomes a complete one-byte entry.

Software and the block share a slot-full flag in bit 15 of each status word. The block reads the flag before it uses a slot. If the flag is still set, the block leaves the slot alone and pulses an overflow interrupt. Memory is modelled as a simple single-cycle port: a read returns its data on the cycle after it is issued, and a write completes at the clock edge.

Top module: `mrx_event_writer`

## Requirements
- R1: In dual-reception mode (`single_rx_mode`=0), a byte counts only when its value equals the byte received just before it on the same port. A third or later identical reception does not count again. A different value restarts the comparison.
- R2: In single-reception mode, every byte strobe produces one entry. Its status has odd/abort/first/last = 1/0/1/1 and its data word is {8'hFF, byte}. End-of-message and abort strobes produce no entry in this mode.
- R3: In dual-reception mode, two counted bytes produce an entry whose data word holds the earlier byte in bits 7:0 and the later byte in bits 15:8. The entry has odd=0, last=0 and abort=0. First=1 is set only on the first such entry of a message.
- R4: End of message with one byte pending writes odd=1, last=1 and data {8'h00, byte}, with first=1 only if it is the message's only byte. With nothing pending it writes odd=0, last=1, first=0 and data 0.
- R5: Abort writes abort=1 and last=0. A pending byte is flushed with odd=1 in the data word's low byte. Without a pending byte the entry has odd=0 and data 0.
- R6: The status word has the slot-full flag at bit 15, the port at bit 10, odd at bit 3, abort at bit 2, first at bit 1 and last at bit 0. All other bits are 0.
- R7: Before writing, the block reads the status word of the slot. It writes the slot only if bit 15 was 0. The data and time-stamp words are written first, and the status word, with bit 15 set, is written last.
- R8: If bit 15 of the slot is already 1, nothing is written, the queue pointer stays where it is, and `ovf_irq` is high for exactly one cycle.
- R9: Each entry starts at a multiple of the slot stride (4 words with time stamping, otherwise 2). The pointer starts at 0 and wraps to 0 at 2^`q_lg2` words. No address at or above that limit is ever accessed.
- R10: With time stamping, word 2 of a slot holds a 16-bit counter that advances once per clock. The difference between two entries' stamps equals the number of cycles between their causing strobes, modulo 2^16.
- R11: While reset is asserted, `mem_we`, `mem_re` and `ovf_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_rx_mode | input | 1 | 1: single-reception mode; 0: dual-reception mode |
| q_lg2 | input | QW | log2 of the queue size in words |
| rx_byte_vld | input | 1 | One-cycle strobe: a monitor byte was received |
| rx_byte | input | 8 | Received byte |
| rx_port | input | 1 | Port on which the strobe occurred |
| rx_eom | input | 1 | One-cycle strobe: end of message on `rx_port` |
| rx_abort | input | 1 | One-cycle strobe: message aborted on `rx_port` |
| mem_addr | output | AW | Queue memory word address |
| mem_we | output | 1 | Queue memory write enable |
| mem_re | output | 1 | Queue memory read enable (data returns next cycle) |
| mem_wdata | output | 16 | Queue memory write data |
| mem_rdata | input | 16 | Queue memory read data |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The hardest case to reach is a slot that software has not yet consumed, because the block itself only ever sets the slot-full flag. The bench owns the memory model. Before sending a byte it presets bit 15 in the slot the pointer will reach next. It then confirms that the data word stays untouched and that the interrupt pulses once. After clearing the flag, it confirms that the next entry lands in that same slot. The sweep uses a 16-word queue, so the pointer wraps many times, and each message is built so that the expected words follow from simple arithmetic on the message index.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

   localparam int unsigned ST_FULL  = 15;
   localparam int unsigned ST_PORT  = 10;
   localparam int unsigned ST_ODD   = 3;
   localparam int unsigned ST_ABT   = 2;
   localparam int unsigned ST_FIRST = 1;
   localparam int unsigned ST_LAST  = 0;

   typedef struct packed {
      logic        odd;
      logic        abt;
      logic        first;
      logic        last;
      logic [15:0] data;
   } mrx_event_t;

   typedef enum logic [2:0] {
      W_IDLE,
      W_READ,
      W_CHECK,
      W_DATA,
      W_STAMP,
      W_STATUS
   } mrx_wr_state_t;

endpackage

// File: rtl/mrx_chan.sv
module mrx_chan
   import mrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       single_rx,
   input  logic       byte_stb,
   input  logic [7:0] byte_in,
   input  logic       eom_stb,
   input  logic       abt_stb,
   output logic       ev_vld,
   output mrx_event_t ev
);

   logic [7:0] cand;
   logic       cand_v;
   logic       taken;
   logic [7:0] pend;
   logic       pend_v;
   logic       first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_vld <= 1'b0;
         ev     <= '0;
         cand   <= '0;
         cand_v <= 1'b0;
         taken  <= 1'b0;
         pend   <= '0;
         pend_v <= 1'b0;
         first  <= 1'b1;
      end else begin
         ev_vld <= 1'b0;
         if (single_rx) begin
            if (byte_stb) begin
               ev_vld   <= 1'b1;
               ev.odd   <= 1'b1;
               ev.abt   <= 1'b0;
               ev.first <= 1'b1;
               ev.last  <= 1'b1;
               ev.data  <= {8'hFF, byte_in};
            end
         end else if (eom_stb || abt_stb) begin
            ev_vld   <= 1'b1;
            ev.odd   <= pend_v;
            ev.abt   <= abt_stb;
            ev.first <= first & pend_v;
            ev.last  <= ~abt_stb;
            ev.data  <= pend_v ? {8'h00, pend} : 16'h0000;
            pend_v   <= 1'b0;
            first    <= 1'b1;
            cand_v   <= 1'b0;
            taken    <= 1'b0;
         end else if (byte_stb) begin
            if (!cand_v || byte_in != cand) begin
               cand   <= byte_in;
               cand_v <= 1'b1;
               taken  <= 1'b0;
            end else if (!taken) begin
               taken <= 1'b1;
               if (pend_v) begin
                  ev_vld   <= 1'b1;
                  ev.odd   <= 1'b0;
                  ev.abt   <= 1'b0;
                  ev.first <= first;
                  ev.last  <= 1'b0;
                  ev.data  <= {byte_in, pend};
                  pend_v   <= 1'b0;
                  first    <= 1'b0;
               end else begin
                  pend   <= byte_in;
                  pend_v <= 1'b1;
               end
            end
         end
      end
   end

   // R2: a byte in single-reception mode always yields an entry
   assert_single_rx_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (single_rx && byte_stb) |=> ev_vld);

   // R1: the first reception of a value never yields an entry by itself
   assert_first_copy_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_rx && byte_stb && !eom_stb && !abt_stb && !cand_v) |=> !ev_vld);

endmodule

// File: rtl/mrx_queue_writer.sv
module mrx_queue_writer
   import mrx_pkg::*;
#(
   parameter int unsigned AW    = 8,
   parameter int unsigned TS_EN = 1,
   parameter int unsigned QW    = $clog2(AW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [QW-1:0] q_lg2,
   input  logic          ev_vld,
   input  mrx_event_t    ev,
   input  logic          ev_port,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [15:0]   mem_wdata,
   input  logic [15:0]   mem_rdata,
   output logic          ovf_irq
);

   localparam int unsigned STRIDE = (TS_EN != 0) ? 4 : 2;

   if (AW < 3) begin : g_bad_aw
      $error("mrx_queue_writer: AW must be at least 3");
   end
   if (TS_EN > 1) begin : g_bad_ts
      $error("mrx_queue_writer: TS_EN must be 0 or 1");
   end

   mrx_wr_state_t state;
   logic [AW-1:0] ptr;
   mrx_event_t    ev_q;
   logic          port_q;
   logic [15:0]   ts_q;
   logic [15:0]   tcount;
   logic [AW:0]   lim;
   logic [AW:0]   mask;
   logic [AW-1:0] ptr_adv;
   logic [15:0]   status_word;
   logic          unused_rdata;

   assign unused_rdata = ^mem_rdata[14:0];
   assign lim     = (AW + 1)'(1) << q_lg2;
   assign mask    = lim - (AW + 1)'(1);
   assign ptr_adv = (ptr + AW'(STRIDE)) & mask[AW-1:0];

   if (TS_EN != 0) begin : g_stamp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tcount <= '0;
         else        tcount <= tcount + 16'd1;
      end
   end else begin : g_no_stamp
      assign tcount = '0;
   end

   always_comb begin
      status_word           = '0;
      status_word[ST_FULL]  = 1'b1;
      status_word[ST_PORT]  = port_q;
      status_word[ST_ODD]   = ev_q.odd;
      status_word[ST_ABT]   = ev_q.abt;
      status_word[ST_FIRST] = ev_q.first;
      status_word[ST_LAST]  = ev_q.last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= W_IDLE;
         ptr     <= '0;
         ev_q    <= '0;
         port_q  <= 1'b0;
         ts_q    <= '0;
         ovf_irq <= 1'b0;
      end else begin
         ovf_irq <= 1'b0;
         unique case (state)
            W_IDLE: if (ev_vld) begin
               ev_q   <= ev;
               port_q <= ev_port;
               ts_q   <= tcount;
               state  <= W_READ;
            end
            W_READ: state <= W_CHECK;
            W_CHECK: begin
               if (mem_rdata[ST_FULL]) begin
                  ovf_irq <= 1'b1;
                  state   <= W_IDLE;
               end else begin
                  state <= W_DATA;
               end
            end
            W_DATA:  state <= (TS_EN != 0) ? W_STAMP : W_STATUS;
            W_STAMP: state <= W_STATUS;
            W_STATUS: begin
               ptr   <= ptr_adv;
               state <= W_IDLE;
            end
            default: state <= W_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      unique case (state)
         W_READ: mem_re = 1'b1;
         W_DATA: begin
            mem_we    = 1'b1;
            mem_addr  = ptr + AW'(1);
            mem_wdata = ev_q.data;
         end
         W_STAMP: begin
            mem_we    = 1'b1;
            mem_addr  = ptr + AW'(2);
            mem_wdata = ts_q;
         end
         W_STATUS: begin
            mem_we    = 1'b1;
            mem_wdata = status_word;
         end
         default: ;
      endcase
   end

   assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_write_after_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && state == W_DATA) |-> !$past(mem_rdata[ST_FULL]));

   assert_event_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vld |-> state == W_IDLE);

   assert_no_write_on_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (!mem_we && !mem_re));

   assert_ovf_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |=> !ovf_irq);

   assert_addr_in_queue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> ({1'b0, mem_addr} < lim));

endmodule

// File: rtl/mrx_event_writer.sv
module mrx_event_writer
   import mrx_pkg::*;
#(
   parameter int unsigned AW    = 8,
   parameter int unsigned TS_EN = 1,
   parameter int unsigned QW    = $clog2(AW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          single_rx_mode,
   input  logic [QW-1:0] q_lg2,
   input  logic          rx_byte_vld,
   input  logic [7:0]    rx_byte,
   input  logic          rx_port,
   input  logic          rx_eom,
   input  logic          rx_abort,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [15:0]   mem_wdata,
   input  logic [15:0]   mem_rdata,
   output logic          ovf_irq
);

   localparam int unsigned NPORT = 2;

   logic [NPORT-1:0] ch_vld;
   mrx_event_t       ch_ev [NPORT];
   mrx_event_t       sel_ev;
   logic             sel_vld;
   logic             sel_port;

   for (genvar p = 0; p < NPORT; p++) begin : g_chan
      logic hit;
      assign hit = (rx_port == 1'(p));
      mrx_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .single_rx (single_rx_mode),
         .byte_stb  (rx_byte_vld & hit),
         .byte_in   (rx_byte),
         .eom_stb   (rx_eom & hit),
         .abt_stb   (rx_abort & hit),
         .ev_vld    (ch_vld[p]),
         .ev        (ch_ev[p])
      );
   end

   assign sel_vld  = |ch_vld;
   assign sel_port = ch_vld[1];
   assign sel_ev   = ch_vld[1] ? ch_ev[1] : ch_ev[0];

   mrx_queue_writer #(
      .AW    (AW),
      .TS_EN (TS_EN),
      .QW    (QW)
   ) u_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_lg2     (q_lg2),
      .ev_vld    (sel_vld),
      .ev        (sel_ev),
      .ev_port   (sel_port),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .ovf_irq   (ovf_irq)
   );

   assert_one_port_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_vld));

endmodule

// File: tb/mrx_event_writer_bench.sv
`timescale 1ns/1ps
module mrx_event_writer_bench;

   localparam int AW = 8;
   localparam int QW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          single_rx_mode = 1'b0;
   logic [QW-1:0] q_lg2 = 4'd4;
   logic          rx_byte_vld = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          rx_port = 1'b0;
   logic          rx_eom = 1'b0;
   logic          rx_abort = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic          mem_re;
   logic [15:0]   mem_wdata;
   logic [15:0]   mem_rdata = '0;
   logic          ovf_irq;

   logic [15:0] mem [256];
   int  cyc = 0;
   int  ovf_cnt = 0;
   int  checks = 0;
   int  errs = 0;
   int  eptr = 0;
   int  stb_cyc = 0;
   int  prev_cyc = 0;
   logic [15:0] prev_ts = '0;
   bit  have_prev = 0;

   always #2.5 clk = ~clk;

   mrx_event_writer #(.AW(AW), .TS_EN(1), .QW(QW)) u_mrx_event_writer (
      .clk(clk), .rst_n(rst_n), .single_rx_mode(single_rx_mode), .q_lg2(q_lg2),
      .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_port(rx_port),
      .rx_eom(rx_eom), .rx_abort(rx_abort), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovf_irq(ovf_irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ovf_irq) ovf_cnt <= ovf_cnt + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic p, input logic [7:0] b);
      @(negedge clk);
      rx_port = p; rx_byte = b; rx_byte_vld = 1'b1; stb_cyc = cyc;
      @(negedge clk);
      rx_byte_vld = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic send_end(input logic p, input logic abt);
      @(negedge clk);
      rx_port = p; rx_eom = ~abt; rx_abort = abt; stb_cyc = cyc;
      @(negedge clk);
      rx_eom = 1'b0; rx_abort = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   function automatic logic [15:0] st(input logic p, input logic o, input logic a,
                                      input logic f, input logic l);
      return 16'h8000 | (16'(p) << 10) | (16'(o) << 3) | (16'(a) << 2) | (16'(f) << 1) | 16'(l);
   endfunction

   task automatic expect_ev(input string req, input logic p, input logic o, input logic a,
                            input logic f, input logic l, input logic [15:0] d);
      logic [15:0] dts;
      chk({req, " R6 status"}, mem[eptr], st(p, o, a, f, l));
      chk({req, " data"}, mem[eptr+1], d);
      if (have_prev) begin
         dts = mem[eptr+2] - prev_ts;
         chk("R10 stamp delta", dts, 16'(stb_cyc - prev_cyc));
      end
      have_prev = 1; prev_ts = mem[eptr+2]; prev_cyc = stb_cyc;
      for (int i = 0; i < 4; i++) mem[eptr+i] = '0;
      eptr = (eptr + 4) & 15;
   endtask

   task automatic expect_none(input string req);
      chk({req, " no entry status"}, mem[eptr], 0);
      chk({req, " no entry data"}, mem[eptr+1], 0);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

   initial begin
      logic [7:0] bv [4];
      int nz;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R11 we in reset", mem_we, 0);
      chk("R11 re in reset", mem_re, 0);
      chk("R11 ovf in reset", ovf_irq, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 single-reception sweep
      single_rx_mode = 1'b1;
      for (int b = 0; b < 40; b++) begin
         send_byte(1'(b % 2), 8'(b * 6 + 3));
         expect_ev("R2 single byte", 1'(b % 2), 1, 0, 1, 1, {8'hFF, 8'(b * 6 + 3)});
      end
      send_end(1'b0, 1'b0);
      expect_none("R2 end ignored");
      send_end(1'b1, 1'b1);
      expect_none("R2 abort ignored");

      // R3 R4 R5 dual-reception message sweep
      single_rx_mode = 1'b0;
      for (int m = 0; m < 12; m++) begin
         int len; logic p; logic abt;
         len = (m % 4) + 1; p = 1'(m % 2); abt = (m % 3 == 2);
         for (int k = 0; k < len; k++) begin
            bv[k] = 8'(m * 16 + k + 1);
            send_byte(p, bv[k]);
            expect_none("R1 single copy");
            send_byte(p, bv[k]);
            if (k % 2 == 1) expect_ev("R3 pair", p, 0, 0, (k == 1), 0, {bv[k], bv[k-1]});
            else            expect_none("R3 half pair");
         end
         send_end(p, abt);
         if (len % 2 == 1)
            expect_ev(abt ? "R5 abort flush" : "R4 end flush", p, 1, abt, (len == 1), ~abt,
                      {8'h00, bv[len-1]});
         else
            expect_ev(abt ? "R5 abort empty" : "R4 end empty", p, 0, abt, 0, ~abt, 16'h0000);
      end

      // R1 third copy ignored, changed value restarts
      send_byte(1'b0, 8'h5A); send_byte(1'b0, 8'h5A); send_byte(1'b0, 8'h5A);
      expect_none("R1 third copy");
      send_byte(1'b0, 8'hC3); send_byte(1'b0, 8'hC3);
      expect_ev("R1 repeat filter", 0, 0, 0, 1, 0, 16'hC35A);
      send_byte(1'b1, 8'h11); send_byte(1'b1, 8'h22);
      send_byte(1'b1, 8'h11); send_byte(1'b1, 8'h22);
      send_end(1'b1, 1'b0);
      expect_ev("R1 alternating none counted", 1, 0, 0, 0, 1, 16'h0000);
      send_end(1'b0, 1'b0);
      expect_ev("R4 end after pair", 0, 0, 0, 0, 1, 16'h0000);

      // R8 overflow on occupied slot
      single_rx_mode = 1'b1;
      nz = ovf_cnt;
      mem[eptr] = 16'h8000;
      send_byte(1'b1, 8'h77);
      chk("R8 ovf pulse count", ovf_cnt - nz, 1);
      chk("R8 slot status kept", mem[eptr], 16'h8000);
      chk("R8 data untouched", mem[eptr+1], 0);
      mem[eptr] = 16'h0000;
      send_byte(1'b0, 8'h78);
      expect_ev("R8 pointer held", 0, 1, 0, 1, 1, 16'hFF78);
      chk("R8 no extra ovf", ovf_cnt - nz, 1);

      // R9 nothing beyond the 16-word queue
      nz = 0;
      for (int a = 16; a < 256; a++) if (mem[a] != 0) nz++;
      chk("R9 outside queue untouched", nz, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

endmodule